// File: doc/BRIEF.md
# Register-Array Survivor Traceback Unit

This block is the survivor-path stage of a four-state (constraint length three) convolutional decoder. Each accepted trellis step delivers a 4-bit decision vector, one bit per state, together with the 2-bit index of the state that currently holds the smallest path metric. The vector is written once into a fixed slot of a register array. A rotating write index picks the slot, and stored vectors never move after that. A multiplexer network orders the slots by age.

In the same cycle, a 2-bit traced state starts at the best state and steps back through the fifteen most recent vectors, newest first. This depth is five times the constraint length. At each step the decision bit of the current state names its predecessor. The most significant bit of the state reached after the last step is the decoded bit. Only that small state value travels through the structure; the 4-bit vectors stay where they were written.

A two-state controller tracks the fill. It starts in FILL and moves to RUN on the accepted step that completes the first full window (FILL→RUN). It stays in RUN (RUN→RUN) until reset, and reset always returns it to FILL. While in FILL, a step decodes only if it is the fifteenth one.

Top module: `survivor_traceback`

## Requirements
- R1: An active-low asynchronous reset drives out_valid and out_bit to 0, clears the write index and the fill count, and returns the controller to FILL, so that a fresh fill of 15 steps is needed afterwards.
- R2: Each cycle with in_valid high writes in_dec into the slot selected by the write index, which then advances by one; a stored vector is never rewritten until the index comes back to its slot.
- R3: A cycle with in_valid low writes nothing and does not move the write index; in the following cycle out_valid is 0, and later decodes are the same as if the idle cycle had not occurred.
- R4: After reset, out_valid stays 0 for the first 14 accepted steps and is 1 in the cycle after the 15th and after every later accepted step.
- R5: The trace starts at in_best and uses the arriving vector as its newest entry. Bit position s of a vector (in_dec[s]) is the decision d for state s, and the predecessor of state s is {s[0], d}.
- R6: The trace walks exactly 15 vectors, newest to oldest; out_bit is bit 1 of the state reached after the 15th predecessor step.
- R7: out_bit and out_valid are registered and appear one clock after the accepted step; out_bit keeps its value in cycles where out_valid is 0.
- R8: Decoding stays correct when the write index wraps from 14 back to 0, over runs much longer than the depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks an accepted trellis step |
| in_dec | input | 4 | Decision vector, bit s belongs to state s |
| in_best | input | 2 | State with the smallest path metric |
| out_bit | output | 1 | Decoded bit |
| out_valid | output | 1 | out_bit carries a new decision this cycle |

## Verification
Two things happen in the same cycle on every accepted step: the arriving vector is written into its slot, and the same vector is read as the first stage of the trace. The oldest slot in the trace is also the one the next step will overwrite. The bench provokes this collision at every step and at each wrap of the index. It uses long pseudo-random runs with idle gaps and a mid-run reset, and compares each decoded bit against a history model that walks its own record of accepted vectors.

// File: rtl/tbu_pkg.sv
package tbu_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } tbu_state_e;

endpackage

// File: rtl/tbu_ctrl.sv
module tbu_ctrl
    import tbu_pkg::*;
#(
    parameter int DEPTH = 15,
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             fire
);

    typedef logic [PTR_W-1:0] ptr_t;
    localparam ptr_t LAST = ptr_t'(DEPTH - 1);

    tbu_state_e state_q, state_d;
    ptr_t       ptr_q;
    ptr_t       fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (step && fill_q == LAST) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            fill_q <= '0;
        end else if (step) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            if (state_q == ST_FILL && fill_q != LAST)
                fill_q <= fill_q + 1'b1;
        end
    end

    assign wr_ptr = ptr_q;
    assign fire   = step && (state_q == ST_RUN || fill_q == LAST);

    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        step && ptr_q != LAST |=> ptr_q == $past(ptr_q) + 1'b1);

    a_r8_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        step && ptr_q == LAST |=> ptr_q == '0);

    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ptr_q));

    a_r4_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN |=> state_q == ST_RUN);

endmodule

// File: rtl/tbu_store.sv
module tbu_store #(
    parameter int DEPTH = 15,
    parameter int PTR_W = 4,
    parameter int DV_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [PTR_W-1:0]            wr_ptr,
    input  logic [DV_W-1:0]             wr_dec,
    output logic [DEPTH-1:1][DV_W-1:0]  aged
);

    typedef logic [PTR_W-1:0] ptr_t;

    logic [DV_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (we && wr_ptr == ptr_t'(i))
                mem[i] <= wr_dec;
        end

        a_r2_slot_still: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && wr_ptr == ptr_t'(i)) |=> $stable(mem[i]));
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_age
        always_comb begin
            int idx;
            idx = int'(wr_ptr) - k;
            if (idx < 0) idx = idx + DEPTH;
            aged[k] = mem[ptr_t'(idx)];
        end
    end

endmodule

// File: rtl/tbu_trace.sv
module tbu_trace #(
    parameter int DEPTH   = 15,
    parameter int STATE_W = 2,
    parameter int DV_W    = 4
) (
    input  logic [STATE_W-1:0]          start,
    input  logic [DEPTH-1:0][DV_W-1:0]  vecs,
    output logic                        bit_out
);

    logic [STATE_W-1:0] st [DEPTH+1];

    assign st[0] = start;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        assign st[k+1] = {st[k][STATE_W-2:0], vecs[k][st[k]]};
    end

    assign bit_out = st[DEPTH][STATE_W-1];

endmodule

// File: rtl/survivor_traceback.sv
module survivor_traceback
    import tbu_pkg::*;
#(
    parameter int CONSTRAINT_LEN = 3,
    parameter int DEPTH_FACTOR   = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [2**(CONSTRAINT_LEN-1)-1:0] in_dec,
    input  logic [CONSTRAINT_LEN-2:0]   in_best,
    output logic                        out_bit,
    output logic                        out_valid
);

    localparam int STATE_W = CONSTRAINT_LEN - 1;
    localparam int DV_W    = 2 ** STATE_W;
    localparam int DEPTH   = DEPTH_FACTOR * CONSTRAINT_LEN;
    localparam int PTR_W   = $clog2(DEPTH);

    logic [PTR_W-1:0]            wr_ptr;
    logic                        fire;
    logic [DEPTH-1:1][DV_W-1:0]  aged;
    logic [DEPTH-1:0][DV_W-1:0]  window;
    logic                        traced;

    tbu_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (in_valid),
        .wr_ptr (wr_ptr),
        .fire   (fire)
    );

    tbu_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .DV_W(DV_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (in_valid),
        .wr_ptr (wr_ptr),
        .wr_dec (in_dec),
        .aged   (aged)
    );

    assign window = {aged, in_dec};

    tbu_trace #(.DEPTH(DEPTH), .STATE_W(STATE_W), .DV_W(DV_W)) u_trace (
        .start   (in_best),
        .vecs    (window),
        .bit_out (traced)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= fire;
            if (fire) out_bit <= traced;
        end
    end

    a_r7_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_bit));

    a_r7_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

// File: tb/tb_survivor_traceback.sv
module tb_survivor_traceback;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_dec = '0;
    logic [1:0] in_best = '0;
    logic       out_bit, out_valid;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [3:0] hist [4096];
    int   n_acc = 0;
    logic exp_bit = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    survivor_traceback dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dec(in_dec),
        .in_best(in_best), .out_bit(out_bit), .out_valid(out_valid)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(string req, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b at step %0d", req, act, expv, n_acc);
        end
    endtask

    function automatic logic model_bit(logic [1:0] best);
        logic [1:0] s = best;
        for (int k = 0; k < 15; k++) begin
            logic d = hist[n_acc - 1 - k][s];
            s = {s[0], d};
        end
        return s[1];
    endfunction

    function automatic void next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endfunction

    task automatic step(logic v, logic [3:0] dv, logic [1:0] best, string req);
        logic ev;
        @(negedge clk);
        in_valid = v; in_dec = dv; in_best = best;
        if (v) begin
            hist[n_acc] = dv;
            n_acc++;
        end
        ev = v && (n_acc >= 15);
        if (ev) exp_bit = model_bit(best);
        @(posedge clk); #1;
        check({req, " valid"}, out_valid, ev);
        check({req, " bit"}, out_bit, exp_bit);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        n_acc = 0; exp_bit = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check("R1 reset valid", out_valid, 1'b0);
        check("R1 reset bit", out_bit, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_fill();
        for (int i = 0; i < 15; i++) begin
            next_rand();
            step(1'b1, lfsr[3:0], lfsr[5:4], "R4 fill");
        end
    endtask

    task automatic t_constant();
        for (int i = 0; i < 15; i++) step(1'b1, 4'hF, 2'd3, "R5 ones");
        check("R5 ones decodes 1", out_bit, 1'b1);
        for (int i = 0; i < 15; i++) step(1'b1, 4'h0, 2'd3, "R6 zeros");
        check("R6 zeros decodes 0", out_bit, 1'b0);
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 30; i++) begin
            next_rand();
            if (lfsr[7:6] == 2'b00) step(1'b0, lfsr[3:0], lfsr[5:4], "R3 idle");
            else step(1'b1, lfsr[3:0], lfsr[5:4], "R7 gap");
        end
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 60; i++) begin
            next_rand();
            step(1'b1, lfsr[3:0], lfsr[9:8], "R8 wrap");
        end
    endtask

    task automatic t_midreset();
        for (int i = 0; i < 7; i++) begin
            next_rand();
            step(1'b1, lfsr[3:0], lfsr[5:4], "R2 pre");
        end
        do_reset();
        for (int i = 0; i < 20; i++) begin
            next_rand();
            step(1'b1, lfsr[3:0], lfsr[5:4], "R1 refill");
        end
    endtask

    initial begin
        do_reset();
        t_fill();
        t_constant();
        t_gaps();
        t_wrap();
        t_midreset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule